// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Predictor

This block watches the stream of memory accesses made by load and store instructions. It learns, separately for each instruction, the distance between successive addresses. Every access presents the instruction's program counter and its effective address. A small direct-mapped table, indexed and tagged by the program counter, keeps the previous address, the previous stride and a confidence count for that instruction. Because each instruction has its own entry, two address streams that interleave in time are tracked apart.

Once an instruction has repeated the same non-zero stride often enough, the block sends one or more prefetch addresses ahead of that instruction's current address. Each prefetch address is the current address plus a multiple of the stride. The number of addresses grows with confidence, up to a set limit. Prefetch addresses leave through a valid/ready port that feeds a request queue. While a burst is still being handed off, the block refuses new accesses.

Top module: `stride_rpt`

## Requirements
- R1: Out of reset no table entry is valid, `pf_valid` is 0 and `acc_ready` is 1.
- R2: An access is accepted on a clock edge where `acc_valid` and `acc_ready` are both 1. The entry is selected by `acc_pc[5:2]` (IDX_W=4) and the tag is the whole PC. On a miss (entry invalid or tag different), the entry is taken over with stride 0 and count 0. The entry records the access address, and no prefetch follows.
- R3: On a hit where the new stride (access address minus stored address) equals the stored stride, the count increases by one. A prefetch burst follows only when the updated count is greater than THRESH (default 1).
- R4: On a hit with a different stride, the count is cleared and the stored stride becomes the new stride. No prefetch follows. On every access, hit or miss, the stored address becomes the access address.
- R5: The burst holds min(count − THRESH, MAX_DEPTH) addresses (MAX_DEPTH default 3). They are the access address plus 1×, 2×, … × stride, sent in increasing order. The arithmetic wraps modulo 2^ADDR_W, so negative strides work.
- R6: The count saturates at 2^CNT_W − 1 (7 by default) and never wraps. Further matching accesses keep producing full-depth bursts.
- R7: When the stored stride is zero, no prefetch is issued, whatever the count.
- R8: Two instructions whose PCs select different entries keep separate strides and counts, even when their accesses alternate.
- R9: An instruction whose PC selects an entry held by another PC evicts it. The evicted instruction then starts learning again from a miss.
- R10: A prefetch address is held stable while `pf_valid` is 1 and `pf_ready` is 0. `acc_ready` is 0 while any prefetch of the current burst is pending. `pf_valid` rises only in the cycle after an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is offered |
| acc_ready | output | 1 | The block can take an access this cycle |
| acc_pc | input | PC_W | Program counter of the accessing instruction |
| acc_addr | input | ADDR_W | Effective address of the access |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | The request queue takes the offered address |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
A training run shows that the first prefetch comes on the fourth strided access. A design that counted the allocating miss, or kept the count on a stride change, would prefetch one or two accesses early. A long run of matching accesses exposes a count that wraps, because the bursts would suddenly stop. A repeated identical address shows whether a zero stride leaks out as useless prefetches. Alternating two instructions shows whether strides are shared. Two PCs that share an index show whether the tag compare is missing. A descending stride catches sign errors. With back-pressure on the prefetch port, the bench checks that addresses are not dropped or repeated, and that no access is taken mid-burst.

// File: rtl/stride_rpt.sv
module stride_rpt #(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 3,
  parameter int THRESH    = 1,
  parameter int MAX_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [PC_W-1:0]   acc_pc,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int DEP_W   = $clog2(MAX_DEPTH + 1);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [ENTRIES-1:0] ent_v;
  logic [PC_W-1:0]    ent_tag    [ENTRIES];
  logic [ADDR_W-1:0]  ent_last   [ENTRIES];
  logic [ADDR_W-1:0]  ent_stride [ENTRIES];
  logic [CNT_W-1:0]   ent_cnt    [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic              hit, same, accept;
  logic [ADDR_W-1:0] new_stride, str_next;
  logic [CNT_W-1:0]  cnt_next;
  logic [DEP_W-1:0]  depth_next, left;
  logic [ADDR_W-1:0] issue_stride, pf_addr_r;

  assign idx        = acc_pc[IDX_W+1:2];
  assign hit        = ent_v[idx] && (ent_tag[idx] == acc_pc);
  assign new_stride = acc_addr - ent_last[idx];
  assign same       = new_stride == ent_stride[idx];
  assign accept     = acc_valid && acc_ready;
  assign acc_ready  = left == '0;
  assign pf_valid   = left != '0;
  assign pf_addr    = pf_addr_r;

  always_comb begin
    if (!hit) begin
      cnt_next = '0;
      str_next = '0;
    end else if (same) begin
      cnt_next = (int'(ent_cnt[idx]) == CNT_MAX) ? ent_cnt[idx] : ent_cnt[idx] + 1'b1;
      str_next = ent_stride[idx];
    end else begin
      cnt_next = '0;
      str_next = new_stride;
    end
  end

  always_comb begin
    if (str_next == '0 || int'(cnt_next) <= THRESH)
      depth_next = '0;
    else if (int'(cnt_next) - THRESH >= MAX_DEPTH)
      depth_next = DEP_W'(MAX_DEPTH);
    else
      depth_next = DEP_W'(int'(cnt_next) - THRESH);
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      ent_tag[idx]    <= acc_pc;
      ent_last[idx]   <= acc_addr;
      ent_stride[idx] <= str_next;
      ent_cnt[idx]    <= cnt_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v        <= '0;
      left         <= '0;
      pf_addr_r    <= '0;
      issue_stride <= '0;
    end else if (accept) begin
      ent_v[idx]   <= 1'b1;
      left         <= depth_next;
      pf_addr_r    <= acc_addr + str_next;
      issue_stride <= str_next;
    end else if (pf_valid && pf_ready) begin
      left      <= left - 1'b1;
      pf_addr_r <= pf_addr_r + issue_stride;
    end
  end
endmodule

module stride_rpt_chk #(parameter int ADDR_W = 32) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [ADDR_W-1:0] issue_stride
);
  a_r10_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));
  a_r10_rise_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_valid) |-> $past(acc_valid && acc_ready));
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready && !(acc_valid && acc_ready)) |=>
      (!pf_valid || pf_addr == $past(pf_addr) + $past(issue_stride)));
  a_r7_no_zero_stride: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> issue_stride != '0);
endmodule

bind stride_rpt stride_rpt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
  .issue_stride(issue_stride));

// File: tb/sim_stride_rpt.sv
module sim_stride_rpt;
  logic clk = 0, rst_n = 0, acc_valid = 0, pf_ready = 1;
  logic [31:0] acc_pc = 0, acc_addr = 0;
  logic acc_ready, pf_valid;
  logic [31:0] pf_addr;
  int checks = 0, fails = 0;
  bit bp = 0, done = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  stride_rpt u0 (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_pc(acc_pc), .acc_addr(acc_addr), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr));

  logic [31:0] exp_q[$];
  string tag_q[$];
  string cur = "R1";

  bit m_v[16];
  logic [31:0] m_tag[16], m_last[16], m_str[16];
  int m_cnt[16];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 pf_ready <= bp ? (cyc % 3 != 0) : 1'b1;
  end

  always @(negedge clk) if (rst_n && pf_valid) begin
    checks++;
    if (acc_ready) begin fails++; $display("FAIL R10 acc_ready=%0d expected 0 during burst", acc_ready); end
    if (pf_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++; $display("FAIL %s unexpected prefetch %h expected none", cur, pf_addr);
      end else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (pf_addr !== e) begin fails++; $display("FAIL %s pf_addr=%h expected %h", t, pf_addr, e); end
      end
    end
  end

  task automatic access(input logic [31:0] pc, input logic [31:0] addr);
    int i = int'(pc[5:2]);
    logic [31:0] ns;
    if (m_v[i] && m_tag[i] == pc) begin
      ns = addr - m_last[i];
      if (ns == m_str[i]) m_cnt[i] = (m_cnt[i] == 7) ? 7 : m_cnt[i] + 1;
      else begin m_cnt[i] = 0; m_str[i] = ns; end
    end else begin
      m_v[i] = 1; m_tag[i] = pc; m_str[i] = 0; m_cnt[i] = 0;
    end
    m_last[i] = addr;
    if (m_str[i] != 0 && m_cnt[i] > 1)
      for (int k = 1; k <= ((m_cnt[i] - 1 > 3) ? 3 : m_cnt[i] - 1); k++) begin
        exp_q.push_back(addr + 32'(k) * m_str[i]); tag_q.push_back(cur);
      end
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1; acc_pc = pc; acc_addr = addr;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || pf_valid) && n < 200) begin @(negedge clk); n++; end
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL %s %0d prefetches missing, expected 0", cur, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  initial begin
    #3000000;
    checks++; fails++; $display("FAIL watchdog expired, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks += 2;
    if (pf_valid !== 0) begin fails++; $display("FAIL R1 pf_valid=%0d expected 0", pf_valid); end
    if (acc_ready !== 1) begin fails++; $display("FAIL R1 acc_ready=%0d expected 1", acc_ready); end

    cur = "R2";
    for (int j = 0; j < 3; j++) access(32'h418, 32'h9000 + 32'(j) * 64);
    drain();

    cur = "R3";
    for (int j = 0; j < 5; j++) access(32'h100, 32'h1000 + 32'(j) * 8);
    drain();
    cur = "R5"; bp = 1;
    for (int j = 5; j < 9; j++) access(32'h100, 32'h1000 + 32'(j) * 8);
    drain(); bp = 0;
    cur = "R6";
    for (int j = 9; j < 20; j++) access(32'h100, 32'h1000 + 32'(j) * 8);
    drain();

    cur = "R4";
    access(32'h100, 32'h5000);
    access(32'h100, 32'h5020);
    access(32'h100, 32'h5040);
    access(32'h100, 32'h5060);
    drain();

    cur = "R7";
    for (int j = 0; j < 6; j++) access(32'h204, 32'h7777_0000);
    drain();

    cur = "R8"; bp = 1;
    for (int j = 0; j < 7; j++) begin
      access(32'h308, 32'h2000 + 32'(j) * 16);
      access(32'h30c, 32'h8000 - 32'(j) * 4);
    end
    drain(); bp = 0;

    cur = "R9";
    access(32'h140, 32'hA000);
    access(32'h100, 32'h5080);
    access(32'h100, 32'h50A0);
    access(32'h100, 32'h50C0);
    access(32'h100, 32'h50E0);
    drain();

    cur = "R10"; bp = 1;
    for (int j = 0; j < 8; j++) access(32'h3f0, 32'hFFFF_FF00 + 32'(j) * 32);
    drain(); bp = 0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule